// File: doc/BRIEF.md
# SMBus Register Read Target

This block is a target on a two-wire SMBus. It lets a bus master read a bank of 8-bit registers that sit outside the block, and it takes part in three read transactions. A single-byte read returns one register. A word read returns a register and then its upper neighbour. A block process call returns a length byte followed by a run of consecutive registers. The master picks the run's start and length in the write phase of the call.

Both bus lines enter as sampled inputs and pass through synchronizers clocked by the system clock. The block pulls SDA low by raising an enable output and never drives it high. It does not drive SCL at all. Registers are fetched through a simple synchronous port: the block presents an address, and the register file returns that location's byte one clock later.

A write phase that carries only a register byte, closed by STOP, loads the internal pointer. A later read that goes straight to the read address then continues from that pointer.

Top module: `smb_reg_reader`

## Requirements
- R1: The target ACKs three bytes: its own 7-bit address followed by a low direction bit, the register or command byte that follows, and its address with a high direction bit after a repeated START. While acknowledging, it holds SDA low for the whole ninth clock.
- R2: In a single-byte read the target returns the register at the address given in the write phase, sending the most significant bit first.
- R3: In a word read the target first returns the register at address n. After the master ACKs, it returns the register at n+1.
- R4: A command byte of F1h starts a block process call. The target ACKs a following length byte only if it equals 2. It then ACKs a start-address byte and a requested-count byte.
- R5: After a valid block header and a repeated START with the read address, the target first returns a byte equal to the requested count. It then returns that many registers, starting at the start address and moving upward.
- R6: A START followed by any 7-bit address other than the configured one gets no ACK. The target leaves SDA released for every later byte until the next START.
- R7: Three header bytes are NACKed at the byte itself: a block-call length other than 2, a requested count of 0, and a requested count above 32. Once it has NACKed, the target ACKs no further byte of that transaction.
- R8: When a word or block read runs past register FFh, the register address wraps to 00h.
- R9: A write phase of a single register byte closed by STOP stores that address. A following transaction of START and read address alone returns the register at the stored address.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, and after the master NACKs a byte, the target keeps SDA released until a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL wire |
| sda_i | input | 1 | Sampled level of the SDA wire |
| sda_oe | output | 1 | When high, the block pulls SDA low |
| reg_addr | output | AW | Address of the register to be fetched |
| reg_data | input | 8 | Register byte for reg_addr, valid one clock after the address |

## Verification
The embedded properties assume a master that does not clock-stretch and that moves SDA while SCL is high only to make a START or a STOP. They also assume that each SCL half-period lasts much longer than the synchronizer delay, so that every bus event reaches the control logic in the phase of SCL it belongs to. The bench acts as that master. It changes SDA only one quarter-period after an SCL fall, and it holds each SCL level for twenty system clocks. It compares every returned byte and every acknowledge bit against a behavioural model of the register bank and its pointer. It also watches the drive enable on every clock and reports any change made while SCL is high.

// File: rtl/smb_pkg.sv
package smb_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_RX,
      S_ACK,
      S_TX,
      S_TACK,
      S_WAIT
   } smb_state_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   generate
      if (STAGES < 2) begin : g_stage_chk
         $error("smb_line_sync: STAGES must be 2 or more");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_shift.sv
module smb_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_en,
   input  logic         rx_bit,
   input  logic         ld_en,
   input  logic [W-1:0] ld_val,
   input  logic         tx_adv,
   output logic [W-1:0] rx_word,
   output logic [W-1:0] rx_held,
   output logic         tx_after
);
   generate
      if (W < 2) begin : g_w_chk
         $error("smb_shift: W must be 2 or more");
      end
   endgenerate

   logic [W-1:0] rx_sh;
   logic [W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh <= '0;
         tx_sh <= '1;
      end else begin
         if (rx_en) rx_sh <= {rx_sh[W-2:0], rx_bit};
         if (ld_en) tx_sh <= ld_val;
         else if (tx_adv) tx_sh <= {tx_sh[W-2:0], 1'b1};
      end
   end

   assign rx_word  = {rx_sh[W-2:0], rx_bit};
   assign rx_held  = rx_sh;
   assign tx_after = tx_sh[W-2];
endmodule

// File: rtl/smb_reg_reader.sv
module smb_reg_reader
   import smb_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2D,
   parameter logic [7:0] BLK_CMD     = 8'hF1,
   parameter logic [7:0] HDR_LEN     = 8'd2,
   parameter int         MAX_CNT     = 32,
   parameter int         AW          = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   output logic [AW-1:0] reg_addr,
   input  logic [7:0]    reg_data
);
   localparam logic [7:0] MAX_B = 8'(MAX_CNT);

   generate
      if (MAX_CNT < 1 || MAX_CNT > 255) begin : g_cnt_chk
         $error("smb_reg_reader: MAX_CNT out of range");
      end
      if (AW < 1 || AW > BYTE_W) begin : g_aw_chk
         $error("smb_reg_reader: AW must be 1..8");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt, busev;
   logic [7:0] rx_word, rx_held, tx_val;
   logic tx_after, rx_en, ld_en, tx_adv;

   smb_state_e   st;
   logic [2:0]   bitc;
   logic [2:0]   widx;
   logic         full, ack_go, is_addr, rd_dir, blk, armed, send_cnt, m_ack, oe;
   logic [AW-1:0] ptr;
   logic [7:0]   bcount;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   smb_shift #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(sda_s),
      .ld_en(ld_en), .ld_val(tx_val), .tx_adv(tx_adv),
      .rx_word(rx_word), .rx_held(rx_held), .tx_after(tx_after)
   );

   assign busev  = start_evt | stop_evt;
   assign tx_val = send_cnt ? bcount : reg_data;
   assign rx_en  = !busev && st == S_RX && scl_rise;
   assign tx_adv = !busev && st == S_TX && scl_fall && bitc != 3'd7;
   assign ld_en  = !busev && scl_fall &&
                   ((st == S_ACK && rd_dir) || (st == S_TACK && m_ack));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         bitc     <= '0;
         widx     <= '0;
         full     <= 1'b0;
         ack_go   <= 1'b0;
         is_addr  <= 1'b0;
         rd_dir   <= 1'b0;
         blk      <= 1'b0;
         armed    <= 1'b0;
         send_cnt <= 1'b0;
         m_ack    <= 1'b0;
         oe       <= 1'b0;
         ptr      <= '0;
         bcount   <= '0;
      end else if (start_evt) begin
         st      <= S_RX;
         bitc    <= '0;
         full    <= 1'b0;
         is_addr <= 1'b1;
         oe      <= 1'b0;
         m_ack   <= 1'b0;
      end else if (stop_evt) begin
         st       <= S_IDLE;
         oe       <= 1'b0;
         m_ack    <= 1'b0;
         blk      <= 1'b0;
         armed    <= 1'b0;
         send_cnt <= 1'b0;
      end else begin
         case (st)
            S_RX: begin
               if (scl_rise) begin
                  bitc <= bitc + 3'd1;
                  if (bitc == 3'd7) begin
                     full <= 1'b1;
                     if (is_addr) begin
                        ack_go <= (rx_word[7:1] == DEV_ADDR);
                        if (rx_word[7:1] == DEV_ADDR) begin
                           rd_dir <= rx_word[0];
                           if (!rx_word[0]) widx <= '0;
                           else begin
                              send_cnt <= armed;
                              armed    <= 1'b0;
                           end
                        end
                     end else if (widx == 3'd0) begin
                        ack_go <= 1'b1;
                        widx   <= 3'd1;
                        armed  <= 1'b0;
                        if (rx_word == BLK_CMD) blk <= 1'b1;
                        else begin
                           blk <= 1'b0;
                           ptr <= rx_word[AW-1:0];
                        end
                     end else if (blk && widx == 3'd1) begin
                        ack_go <= (rx_word == HDR_LEN);
                        widx   <= 3'd2;
                     end else if (blk && widx == 3'd2) begin
                        ack_go <= 1'b1;
                        ptr    <= rx_word[AW-1:0];
                        widx   <= 3'd3;
                     end else if (blk && widx == 3'd3) begin
                        ack_go <= (rx_word != 8'd0) && (rx_word <= MAX_B);
                        armed  <= (rx_word != 8'd0) && (rx_word <= MAX_B);
                        bcount <= rx_word;
                        widx   <= 3'd4;
                     end else begin
                        ack_go <= 1'b0;
                     end
                  end
               end else if (scl_fall && full) begin
                  full <= 1'b0;
                  if (ack_go) begin
                     oe <= 1'b1;
                     st <= S_ACK;
                  end else begin
                     st <= S_WAIT;
                  end
               end
            end
            S_ACK: begin
               if (scl_fall) begin
                  is_addr <= 1'b0;
                  bitc    <= '0;
                  if (rd_dir) begin
                     st       <= S_TX;
                     oe       <= ~tx_val[7];
                     send_cnt <= 1'b0;
                     if (!send_cnt) ptr <= ptr + 1'b1;
                  end else begin
                     st   <= S_RX;
                     oe   <= 1'b0;
                     full <= 1'b0;
                  end
               end
            end
            S_TX: begin
               if (scl_fall) begin
                  if (bitc == 3'd7) begin
                     oe <= 1'b0;
                     st <= S_TACK;
                  end else begin
                     oe   <= ~tx_after;
                     bitc <= bitc + 3'd1;
                  end
               end
            end
            S_TACK: begin
               if (scl_rise) begin
                  if (sda_s) st <= S_WAIT;
                  else m_ack <= 1'b1;
               end else if (scl_fall && m_ack) begin
                  m_ack    <= 1'b0;
                  st       <= S_TX;
                  bitc     <= '0;
                  oe       <= ~tx_val[7];
                  send_cnt <= 1'b0;
                  if (!send_cnt) ptr <= ptr + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe   = oe;
   assign reg_addr = ptr;

   // R10
   sda_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R1
   ack_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ACK) |-> sda_oe);

   // R6
   own_addr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ACK && is_addr) |-> (rx_held[7:1] == DEV_ADDR));

   // R7
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (bcount != 8'd0 && bcount <= MAX_B));

   // R11
   released_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE || st == S_WAIT) |-> !sda_oe);
endmodule

// File: tb/smb_reg_reader_test.sv
`timescale 1ns/1ps
module smb_reg_reader_test;
   localparam logic [6:0] DEV = 7'h2D;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic [7:0] reg_addr;
   logic [7:0] reg_data;
   logic [7:0] mem [256];
   logic [7:0] exp_q [$];
   int total = 0;
   int bad = 0;
   int mon_viol = 0;
   bit done = 1'b0;
   logic oe_prev = 1'b0;
   logic scl_prev = 1'b1;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   smb_reg_reader #(.DEV_ADDR(DEV)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_data(reg_data)
   );

   always_ff @(posedge clk) reg_data <= mem[reg_addr];

   // R10 monitor: drive enable must hold while SCL stays high
   always @(negedge clk) begin
      if (rst_n && scl_m && scl_prev && (sda_oe !== oe_prev)) begin
         mon_viol++;
         $display("FAIL R10 sda_oe moved during SCL high: actual=%0b expected=%0b", sda_oe, oe_prev);
      end
      oe_prev  <= sda_oe;
      scl_prev <= scl_m;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; w(Q);
      sda_m = 1'b0; w(Q);
      scl_m = 1'b0; w(Q);
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; w(Q);
      scl_m = 1'b1; w(Q);
      sda_m = 1'b0; w(Q);
      scl_m = 1'b0; w(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; w(Q);
      scl_m = 1'b1; w(Q);
      sda_m = 1'b1; w(2*Q);
   endtask

   task automatic clk_bit(input bit v, output bit s);
      sda_m = v; w(Q);
      scl_m = 1'b1; w(Q);
      s = sda_line; w(Q);
      scl_m = 1'b0; w(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = !s;
   endtask

   task automatic rd_byte(input bit mack, output logic [7:0] b);
      bit s;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         clk_bit(1'b1, s);
         b = {b[6:0], s};
      end
      clk_bit(!mack, s);
   endtask

   task automatic rd_txn(input logic [7:0] cmd, input int n, input bit probe, input string tag);
      bit a;
      logic [7:0] b;
      bus_start();
      wr_byte({DEV, 1'b0}, a); chk(a, "R1 write address ack", a, 1);
      wr_byte(cmd, a);         chk(a, "R1 register byte ack", a, 1);
      bus_rstart();
      wr_byte({DEV, 1'b1}, a); chk(a, "R1 read address ack", a, 1);
      for (int i = 0; i < n; i++) begin
         rd_byte(i != n - 1, b);
         chk(b == mem[8'(cmd + i)], tag, b, mem[8'(cmd + i)]);
      end
      if (probe) begin
         rd_byte(1'b0, b);
         chk(b == 8'hFF, "R11 released after master NACK", b, 8'hFF);
      end
      bus_stop();
   endtask

   task automatic blk_txn(input logic [7:0] sa, input logic [7:0] cnt, input string tag);
      bit a;
      logic [7:0] b;
      logic [7:0] e;
      exp_q.delete();
      exp_q.push_back(cnt);
      for (int i = 0; i < int'(cnt); i++) exp_q.push_back(mem[8'(sa + i)]);
      bus_start();
      wr_byte({DEV, 1'b0}, a); chk(a, "R1 write address ack", a, 1);
      wr_byte(8'hF1, a);       chk(a, "R4 block command ack", a, 1);
      wr_byte(8'd2, a);        chk(a, "R4 header length ack", a, 1);
      wr_byte(sa, a);          chk(a, "R4 start address ack", a, 1);
      wr_byte(cnt, a);         chk(a, "R4 count ack", a, 1);
      bus_rstart();
      wr_byte({DEV, 1'b1}, a); chk(a, "R1 read address ack", a, 1);
      for (int i = 0; i <= int'(cnt); i++) begin
         rd_byte(i != int'(cnt), b);
         e = exp_q.pop_front();
         chk(b == e, tag, b, e);
      end
      bus_stop();
   endtask

   task automatic blk_bad(input logic [7:0] len, input logic [7:0] cnt, input bit bad_len);
      bit a;
      bus_start();
      wr_byte({DEV, 1'b0}, a); chk(a, "R1 write address ack", a, 1);
      wr_byte(8'hF1, a);       chk(a, "R4 block command ack", a, 1);
      wr_byte(len, a);
      if (bad_len) begin
         chk(!a, "R7 wrong header length NACK", a, 0);
      end else begin
         chk(a, "R4 header length ack", a, 1);
         wr_byte(8'h10, a);    chk(a, "R4 start address ack", a, 1);
         wr_byte(cnt, a);      chk(!a, "R7 bad count NACK", a, 0);
      end
      wr_byte(8'h02, a);       chk(!a, "R7 later byte NACK", a, 0);
      bus_stop();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #1900000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      bit a;
      logic [7:0] b;
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ 8'hA5);
      w(10);
      chk(sda_oe == 1'b0, "R11 reset releases SDA", sda_oe, 0);
      rst_n = 1'b1;
      w(10);
      chk(sda_oe == 1'b0, "R11 idle after reset", sda_oe, 0);

      rd_txn(8'h10, 1, 1'b0, "R2 single byte read");
      rd_txn(8'h7C, 1, 1'b0, "R2 single byte read");
      rd_txn(8'h40, 2, 1'b1, "R3 word read");
      rd_txn(8'hFF, 2, 1'b0, "R8 word read wraps");

      blk_txn(8'h20, 8'd4, "R5 block read");
      blk_txn(8'hFE, 8'd3, "R8 block read wraps");
      blk_txn(8'h80, 8'd32, "R5 block read max count");
      blk_txn(8'h05, 8'd1, "R5 block read min count");

      // R6 foreign address
      bus_start();
      wr_byte({7'h2C, 1'b0}, a); chk(!a, "R6 foreign address NACK", a, 0);
      wr_byte(8'h33, a);         chk(!a, "R6 ignored until START", a, 0);
      bus_stop();
      bus_start();
      wr_byte({7'h55, 1'b1}, a); chk(!a, "R6 foreign read address NACK", a, 0);
      rd_byte(1'b0, b);          chk(b == 8'hFF, "R6 SDA stays released", b, 8'hFF);
      bus_stop();

      // R7 malformed block headers
      blk_bad(8'd3, 8'd4, 1'b1);
      blk_bad(8'd2, 8'd0, 1'b0);
      blk_bad(8'd2, 8'd33, 1'b0);
      rd_txn(8'h21, 1, 1'b0, "R7 recovery read");

      // R9 pointer set by write, read addressed directly
      bus_start();
      wr_byte({DEV, 1'b0}, a); chk(a, "R1 write address ack", a, 1);
      wr_byte(8'h30, a);       chk(a, "R9 pointer byte ack", a, 1);
      bus_stop();
      bus_start();
      wr_byte({DEV, 1'b1}, a); chk(a, "R1 read address ack", a, 1);
      rd_byte(1'b1, b);        chk(b == mem[8'h30], "R9 read from stored pointer", b, mem[8'h30]);
      rd_byte(1'b0, b);        chk(b == mem[8'h31], "R9 pointer advances", b, mem[8'h31]);
      bus_stop();

      w(20);
      chk(mon_viol == 0, "R10 SDA drive changed only with SCL low", mon_viol, 0);
      finish_run();
   end
endmodule